// File: doc/BRIEF.md
# Vector Floating-Point Minimum/Maximum Unit

This unit takes two 128-bit vector operands and returns, lane by lane, the floating-point minimum or maximum of the matching elements. The lanes are either four 32-bit single-precision values or two 64-bit double-precision values. A rule code picks how NaNs and signed zeros are treated: an IEEE-style number-preferring rule, a strict rule that propagates NaN and orders zeros, a plain compare-and-select, and a C-library-style rule. A scalar control limits the work to element 0 and clears the other lanes. The unit performs no arithmetic and raises no exception flags. It only compares by sign and magnitude and detects NaNs.

A request is presented with `in_valid`. One clock later the unit presents the result, a strobe and an illegal-encoding flag. A small state machine records what the last cycle delivered. The states are `ST_IDLE` (no request last cycle), `ST_DONE` (a legal request was completed) and `ST_FAULT` (an illegal encoding was seen). From any state, `in_valid` with a legal encoding moves to `ST_DONE` and `in_valid` with an illegal encoding moves to `ST_FAULT`. Without `in_valid`, every state returns to `ST_IDLE`. Element i occupies bits `[i*W +: W]`, where W is the lane width, so element 0 is the least significant lane.

Top module: `vec_fp_minmax`

## Requirements
- R1: `elem_size` = 2 treats the operands as four 32-bit single-precision lanes. `elem_size` = 3 treats them as two 64-bit double-precision lanes.
- R2: `one_elem` = 0 processes every lane. `one_elem` = 8 processes element 0 only and writes every other lane as zero.
- R3: Any of the following is an illegal encoding: an `elem_size` other than 2 or 3, a `one_elem` other than 0 or 8, or a `nan_mode` outside {0,1,3,4}. On an illegal encoding, `res_illegal` rises with the strobe and `res_data` is all zeros.
- R4: In `nan_mode` 0, if exactly one operand is NaN the other operand is returned, and if both are NaN a NaN is returned. Operands that compare equal, including +0 against -0, return operand A. Otherwise the numerically larger (max) or smaller (min) operand is returned.
- R5: In `nan_mode` 1, a NaN in either operand returns NaN. Max ranks +0 above -0, and min ranks -0 below +0. Otherwise the larger or smaller value is returned.
- R6: In `nan_mode` 3, max returns B only when A < B, and min returns B only when B < A. Every other case, including any NaN, returns A.
- R7: In `nan_mode` 4, a NaN operand gives way to the numeric one, and NaN is returned only when both operands are NaN. Zeros that compare equal return A.
- R8: Any NaN the unit produces is the canonical quiet NaN: 0x7FC00000 for single-precision lanes and 0x7FF8000000000000 for double-precision lanes. A NaN is a value whose exponent is all ones and whose fraction is nonzero.
- R9: `res_valid`, `res_illegal` and `res_data` update on the clock edge that samples `in_valid`. With `in_valid` low, `res_valid` falls on the next edge and `res_data` holds its value.
- R10: While `rst_n` is low, `res_valid`, `res_illegal` and `res_data` are all zero.
- R11: `op_max` = 1 selects the maximum and `op_max` = 0 selects the minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_max | input | 1 | 1 = maximum, 0 = minimum |
| elem_size | input | 4 | Lane size code (2 = single, 3 = double) |
| one_elem | input | 4 | Scalar control (0 = all lanes, 8 = element 0 only) |
| nan_mode | input | 4 | NaN/zero rule code (0, 1, 3, 4) |
| opnd_a | input | 128 | Operand A |
| opnd_b | input | 128 | Operand B |
| res_valid | output | 1 | Result strobe, one clock after the request |
| res_illegal | output | 1 | Illegal encoding seen for this result |
| res_data | output | 128 | Registered result vector |

## Verification
If the state register holds a wrong state, `res_valid` or `res_illegal` disagrees with the request sampled on the previous edge, so the error appears one clock after the bad transition. A fault in lane steering or in a rule shows as a wrong lane value in `res_data` on that same edge. The test vectors pair each rule with NaN, signed-zero, infinity and mixed-sign lanes, so a swapped or wrong branch changes a single visible lane. Running the same bit patterns under both lane sizes shows whether the width decode is wrong.

// File: rtl/vfmm_pkg.sv
package vfmm_pkg;

    localparam int SP_W   = 32;
    localparam int SP_EXP = 8;
    localparam int DP_W   = 64;
    localparam int DP_EXP = 11;

    localparam int SIZE_SP  = 2;
    localparam int SIZE_DP  = 3;
    localparam int ONE_ELEM = 8;
    localparam int ALL_ELEM = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DONE,
        ST_FAULT
    } vfmm_state_e;

    typedef enum logic [1:0] {
        RULE_NUMPREF,
        RULE_STRICT,
        RULE_PLAIN,
        RULE_CLIB
    } vfmm_rule_e;

endpackage

// File: rtl/vfmm_decode.sv
module vfmm_decode
    import vfmm_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] size_code,
    input  logic [CODE_W-1:0] elem_code,
    input  logic [CODE_W-1:0] mode_code,
    output logic              legal,
    output logic              is_dp,
    output logic              single_elem,
    output vfmm_rule_e        rule
);

    logic size_ok;
    logic elem_ok;
    logic mode_ok;

    always_comb begin
        size_ok = 1'b1;
        is_dp   = 1'b0;
        if (size_code == CODE_W'(SIZE_SP)) begin
            is_dp = 1'b0;
        end else if (size_code == CODE_W'(SIZE_DP)) begin
            is_dp = 1'b1;
        end else begin
            size_ok = 1'b0;
        end
    end

    always_comb begin
        elem_ok     = 1'b1;
        single_elem = 1'b0;
        if (elem_code == CODE_W'(ONE_ELEM)) begin
            single_elem = 1'b1;
        end else if (elem_code != CODE_W'(ALL_ELEM)) begin
            elem_ok = 1'b0;
        end
    end

    always_comb begin
        mode_ok = 1'b1;
        rule    = RULE_PLAIN;
        unique case (mode_code)
            CODE_W'(0): rule = RULE_NUMPREF;
            CODE_W'(1): rule = RULE_STRICT;
            CODE_W'(3): rule = RULE_PLAIN;
            CODE_W'(4): rule = RULE_CLIB;
            default:    mode_ok = 1'b0;
        endcase
    end

    assign legal = size_ok & elem_ok & mode_ok;

endmodule

// File: rtl/vfmm_lane.sv
module vfmm_lane
    import vfmm_pkg::*;
#(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_max,
    input  vfmm_rule_e   rule,
    output logic [W-1:0] res
);

    localparam int FW = W - 1 - EW;
    localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    logic         a_sign, b_sign;
    logic [W-2:0] a_mag, b_mag;
    logic         a_nan, b_nan, any_nan, both_zero;
    logic         a_lt_b, b_lt_a, take_b;

    assign a_sign = a[W-1];
    assign b_sign = b[W-1];
    assign a_mag  = a[W-2:0];
    assign b_mag  = b[W-2:0];

    assign a_nan     = (&a[W-2:FW]) & (|a[FW-1:0]);
    assign b_nan     = (&b[W-2:FW]) & (|b[FW-1:0]);
    assign any_nan   = a_nan | b_nan;
    assign both_zero = ~(|a_mag) & ~(|b_mag);

    // Ordered less-than by sign and magnitude; zeros equal, NaN unordered.
    always_comb begin
        a_lt_b = 1'b0;
        b_lt_a = 1'b0;
        if (!any_nan && !both_zero) begin
            unique case ({a_sign, b_sign})
                2'b10: a_lt_b = 1'b1;
                2'b01: b_lt_a = 1'b1;
                2'b00: begin
                    a_lt_b = a_mag < b_mag;
                    b_lt_a = b_mag < a_mag;
                end
                default: begin
                    a_lt_b = a_mag > b_mag;
                    b_lt_a = b_mag > a_mag;
                end
            endcase
        end
    end

    assign take_b = is_max ? a_lt_b : b_lt_a;

    always_comb begin
        res = take_b ? b : a;
        unique case (rule)
            RULE_NUMPREF, RULE_CLIB: begin
                if (a_nan && b_nan) begin
                    res = QNAN;
                end else if (a_nan) begin
                    res = b;
                end else if (b_nan) begin
                    res = a;
                end
            end
            RULE_STRICT: begin
                if (any_nan) begin
                    res = QNAN;
                end else if (a_sign != b_sign) begin
                    res = (a_sign ^ is_max) ? a : b;
                end
            end
            default: begin
                res = take_b ? b : a;
            end
        endcase
    end

    // The result is always one of the operands or the canonical NaN.
    always_comb begin
        p_result_source_r8: assert ((res == a) || (res == b) || (res == QNAN))
            else $error("lane result is neither an operand nor the canonical NaN");
    end

endmodule

// File: rtl/vec_fp_minmax.sv
module vec_fp_minmax
    import vfmm_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_max,
    input  logic [CODE_W-1:0] elem_size,
    input  logic [CODE_W-1:0] one_elem,
    input  logic [CODE_W-1:0] nan_mode,
    input  logic [VEC_W-1:0]  opnd_a,
    input  logic [VEC_W-1:0]  opnd_b,
    output logic              res_valid,
    output logic              res_illegal,
    output logic [VEC_W-1:0]  res_data
);

    localparam int SP_LANES = VEC_W / SP_W;
    localparam int DP_LANES = VEC_W / DP_W;

    logic        legal, is_dp, single_elem;
    vfmm_rule_e  rule;

    vfmm_decode #(.CODE_W(CODE_W)) u_decode (
        .size_code   (elem_size),
        .elem_code   (one_elem),
        .mode_code   (nan_mode),
        .legal       (legal),
        .is_dp       (is_dp),
        .single_elem (single_elem),
        .rule        (rule)
    );

    logic [VEC_W-1:0] sp_vec, dp_vec, next_res;

    for (genvar i = 0; i < SP_LANES; i++) begin : g_sp
        logic [SP_W-1:0] lane_res;
        vfmm_lane #(.W(SP_W), .EW(SP_EXP)) u_lane (
            .a      (opnd_a[i*SP_W +: SP_W]),
            .b      (opnd_b[i*SP_W +: SP_W]),
            .is_max (op_max),
            .rule   (rule),
            .res    (lane_res)
        );
        assign sp_vec[i*SP_W +: SP_W] = (single_elem && i != 0) ? '0 : lane_res;
    end

    for (genvar j = 0; j < DP_LANES; j++) begin : g_dp
        logic [DP_W-1:0] lane_res;
        vfmm_lane #(.W(DP_W), .EW(DP_EXP)) u_lane (
            .a      (opnd_a[j*DP_W +: DP_W]),
            .b      (opnd_b[j*DP_W +: DP_W]),
            .is_max (op_max),
            .rule   (rule),
            .res    (lane_res)
        );
        assign dp_vec[j*DP_W +: DP_W] = (single_elem && j != 0) ? '0 : lane_res;
    end

    assign next_res = !legal ? '0 : (is_dp ? dp_vec : sp_vec);

    // State machine: what the previous cycle delivered.
    vfmm_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (in_valid) begin
                    state_d = legal ? ST_DONE : ST_FAULT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        res_valid   = 1'b0;
        res_illegal = 1'b0;
        unique case (state_q)
            ST_DONE:  res_valid = 1'b1;
            ST_FAULT: begin
                res_valid   = 1'b1;
                res_illegal = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data <= '0;
        end else if (in_valid) begin
            res_data <= next_res;
        end
    end

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid)
        else $error("strobe missing one clock after request");

    p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid)
        else $error("strobe without request");

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_data))
        else $error("result changed without request");

    p_illegal_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> (res_data == '0 && res_valid))
        else $error("illegal result not cleared");

    p_upper_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && single_elem) |=> (res_data[VEC_W-1:DP_W] == '0))
        else $error("upper lanes not cleared in single-element mode");

endmodule

// File: tb/vec_fp_minmax_test.sv
`timescale 1ns/1ps
module vec_fp_minmax_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_max = 1'b0;
    logic [3:0]   elem_size = 4'd0;
    logic [3:0]   one_elem = 4'd0;
    logic [3:0]   nan_mode = 4'd0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         res_valid;
    logic         res_illegal;
    logic [127:0] res_data;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    vec_fp_minmax uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_max(op_max),
        .elem_size(elem_size), .one_elem(one_elem), .nan_mode(nan_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
        .res_illegal(res_illegal), .res_data(res_data)
    );

    typedef struct packed {
        logic [3:0]   req;
        logic         mx;
        logic [3:0]   sz;
        logic [3:0]   sel;
        logic [3:0]   md;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
        logic         ill;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        // R4 max, single lanes: NaN in A, equal zeros, negatives
        '{4'd4, 1'b1, 4'd2, 4'd0, 4'd0, 128'h3F800000_7FC12345_80000000_C0000000,
          128'h40000000_40400000_00000000_BF800000, 128'h40000000_40400000_80000000_BF800000, 1'b0},
        // R4 R11 min, same operands
        '{4'd4, 1'b0, 4'd2, 4'd0, 4'd0, 128'h3F800000_7FC12345_80000000_C0000000,
          128'h40000000_40400000_00000000_BF800000, 128'h3F800000_40400000_80000000_C0000000, 1'b0},
        // R5 max: NaN propagates, +0 above -0
        '{4'd5, 1'b1, 4'd2, 4'd0, 4'd1, 128'h3F800000_7FC12345_80000000_00000000,
          128'h40000000_40400000_00000000_80000000, 128'h40000000_7FC00000_00000000_00000000, 1'b0},
        // R5 min
        '{4'd5, 1'b0, 4'd2, 4'd0, 4'd1, 128'h3F800000_7FC12345_80000000_00000000,
          128'h40000000_40400000_00000000_80000000, 128'h3F800000_7FC00000_80000000_80000000, 1'b0},
        // R6 max: NaN either side gives A
        '{4'd6, 1'b1, 4'd2, 4'd0, 4'd3, 128'h7FC12345_3F800000_80000000_40000000,
          128'h3F800000_7F800001_00000000_40400000, 128'h7FC12345_3F800000_80000000_40400000, 1'b0},
        // R6 min
        '{4'd6, 1'b0, 4'd2, 4'd0, 4'd3, 128'h7FC12345_3F800000_80000000_40000000,
          128'h3F800000_7F800001_00000000_40400000, 128'h7FC12345_3F800000_80000000_40000000, 1'b0},
        // R7 max: NaN yields to number, both NaN gives canonical
        '{4'd7, 1'b1, 4'd2, 4'd0, 4'd4, 128'h7FC12345_3F800000_7F800001_BF800000,
          128'h40000000_7FC00001_7FC12345_C0000000, 128'h40000000_3F800000_7FC00000_BF800000, 1'b0},
        // R7 min
        '{4'd7, 1'b0, 4'd2, 4'd0, 4'd4, 128'h7FC12345_3F800000_7F800001_BF800000,
          128'h40000000_7FC00001_7FC12345_C0000000, 128'h40000000_3F800000_7FC00000_C0000000, 1'b0},
        // R8 double lanes, both NaN in rule 0 gives canonical double NaN
        '{4'd8, 1'b0, 4'd3, 4'd0, 4'd0, 128'h7FF0000000000001_3FF0000000000000,
          128'hFFF8000000000000_BFF0000000000000, 128'h7FF8000000000000_BFF0000000000000, 1'b0},
        // R5 R8 double: zeros ordered, NaN canonical
        '{4'd5, 1'b1, 4'd3, 4'd0, 4'd1, 128'h8000000000000000_3FF0000000000000,
          128'h0000000000000000_7FF8000000000001, 128'h0000000000000000_7FF8000000000000, 1'b0},
        // R2 single element, single lanes
        '{4'd2, 1'b1, 4'd2, 4'd8, 4'd0, 128'h3F800000_3F800000_3F800000_3F800000,
          128'h40000000_40000000_40000000_40400000, 128'h00000000_00000000_00000000_40400000, 1'b0},
        // R2 single element, double lanes
        '{4'd2, 1'b0, 4'd3, 4'd8, 4'd3, 128'h4000000000000000_4000000000000000,
          128'h3FF0000000000000_3FF0000000000000, 128'h0000000000000000_3FF0000000000000, 1'b0},
        // R3 bad size code
        '{4'd3, 1'b1, 4'd1, 4'd0, 4'd0, 128'h3F800000_3F800000_3F800000_3F800000,
          128'h40000000_40000000_40000000_40000000, 128'h0, 1'b1},
        // R3 bad scalar control
        '{4'd3, 1'b1, 4'd2, 4'd4, 4'd0, 128'h3F800000_3F800000_3F800000_3F800000,
          128'h40000000_40000000_40000000_40000000, 128'h0, 1'b1},
        // R3 rule code 2
        '{4'd3, 1'b0, 4'd3, 4'd0, 4'd2, 128'h3FF0000000000000_3FF0000000000000,
          128'h4000000000000000_4000000000000000, 128'h0, 1'b1},
        // R3 rule code 5
        '{4'd3, 1'b0, 4'd2, 4'd0, 4'd5, 128'h3F800000_3F800000_3F800000_3F800000,
          128'h40000000_40000000_40000000_40000000, 128'h0, 1'b1},
        // R7 double: NaN in A yields B, equal zeros give A
        '{4'd7, 1'b1, 4'd3, 4'd0, 4'd4, 128'h7FF0000000000001_8000000000000000,
          128'hC008000000000000_0000000000000000, 128'hC008000000000000_8000000000000000, 1'b0},
        // R4 single: infinities, mixed signs, subnormal
        '{4'd4, 1'b1, 4'd2, 4'd0, 4'd0, 128'hFF800000_7F800000_BF800000_00000001,
          128'h3F800000_40000000_3F800000_80000000, 128'h3F800000_7F800000_3F800000_00000001, 1'b0},
        // R1 same bits as double lanes
        '{4'd1, 1'b1, 4'd3, 4'd0, 4'd0, 128'hFF800000_7F800000_BF800000_00000001,
          128'h3F800000_40000000_3F800000_80000000, 128'h3F800000_40000000_3F800000_80000000, 1'b0}
    };

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid in reset", {127'b0, res_valid}, 128'h0);
        check("R10 illegal in reset", {127'b0, res_illegal}, 128'h0);
        check("R10 data in reset", res_data, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            op_max    = TBL[k].mx;
            elem_size = TBL[k].sz;
            one_elem  = TBL[k].sel;
            nan_mode  = TBL[k].md;
            opnd_a    = TBL[k].a;
            opnd_b    = TBL[k].b;
            in_valid  = 1'b1;
            @(negedge clk);
            in_valid  = 1'b0;
            check($sformatf("R%0d vector %0d data", TBL[k].req, k), res_data, TBL[k].exp);
            check($sformatf("R%0d vector %0d illegal", TBL[k].req, k),
                  {127'b0, res_illegal}, {127'b0, TBL[k].ill});
            check($sformatf("R9 vector %0d strobe", k), {127'b0, res_valid}, 128'h1);
        end

        // R9: known result, then idle cycle holds data and drops strobe
        op_max = 1'b1; elem_size = 4'd2; one_elem = 4'd0; nan_mode = 4'd3;
        opnd_a = 128'h3F800000_3F800000_3F800000_3F800000;
        opnd_b = 128'h40000000_40000000_40000000_40000000;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 back-to-back data", res_data, 128'h40000000_40000000_40000000_40000000);
        opnd_a = '1;
        @(negedge clk);
        check("R9 strobe drops", {127'b0, res_valid}, 128'h0);
        check("R9 data held", res_data, 128'h40000000_40000000_40000000_40000000);

        // R3 then legal: flag clears on next legal request
        elem_size = 4'd7; in_valid = 1'b1;
        @(negedge clk);
        check("R3 flag set", {127'b0, res_illegal}, 128'h1);
        elem_size = 4'd2; opnd_a = 128'h3F800000_3F800000_3F800000_3F800000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 flag clears", {127'b0, res_illegal}, 128'h0);

        // R10 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 data after reset", res_data, 128'h0);
        check("R10 strobe after reset", {127'b0, res_valid}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule